// File: doc/BRIEF.md
# Half-Duplex Time-Division Serial Line Slave Port

This block is the slave end of a three-wire, time-shared serial link. The master provides a bit clock (nominally 512 kHz) and an 8 kHz direction/frame signal. A single data line carries traffic both ways. Each 125 µs frame holds 64 bit slots. While the direction signal is high, the port shifts in 32 bits from the master. While it is low, the port drives 32 bits back on the same line. Each half carries four bytes: a first voice channel, a second voice channel, a control byte and a signaling byte. The port presents the received bytes in parallel with a one-cycle strobe. It takes the bytes to send from parallel inputs.

The data pin is split into an input, an output and an output enable, so the pad ring can build the tristate driver. All link inputs are synchronized into the system clock domain and then edge-detected. Two such ports may share one data line. A strap then decides which voice slot, and which of the control or signaling slots, each port drives. A direction change at an unexpected bit count raises a framing error pulse, and the port realigns to the next frame start.

Top module: `slp_port`

## Requirements
- R1: A frame starts at the rising edge of the direction input. During the high half, data bits are sampled at falling edges of the bit clock, most significant bit first. The first received byte is voice A, then voice B, then control, then signaling.
- R2: After the 32nd received bit of a frame, `rx_valid_o` is high for exactly one clock, and all received byte outputs update in that same cycle. The byte outputs hold their value at all other times, and no strobe occurs during the transmit half.
- R3: `rx_voice_o` carries the voice A byte. When shared mode is selected and the channel strap is high, it carries the voice B byte instead.
- R4: At the falling edge of the direction input, the three transmit byte inputs are captured. The falling edge itself launches the first bit, and each later bit clock rising edge launches the next. Bits go out most significant first, in slot order voice A, voice B, control, signaling.
- R5: With `share_i` low, the single transmit voice byte is sent in both voice slots, and all four slots are driven.
- R6: With `share_i` high and `slot_b_i` low, the port drives only the voice A slot and the control slot. With `slot_b_i` high, it drives only the voice B slot and the signaling slot. The output enable is low in every other slot.
- R7: `sd_oe_o` is low for the whole receive half and for any bit clock rising edges after the 32nd transmit bit. It also drops at the rising edge of the direction input.
- R8: If the direction input falls after a number of received bits other than 32, `frame_err_o` pulses once. The port then does not transmit until the next frame start.
- R9: If the direction input rises after a transmit half that did not have exactly 32 bit-clock rising edges, `frame_err_o` pulses once, and the new frame is still received normally.
- R10: A frame start after reset, or after a half that was abandoned, raises no framing error.
- R11: Synchronous active-high reset clears the output enable, the strobe, the error flag and all received byte outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Link bit clock from the master |
| dir_i | input | 1 | Direction/frame signal: high means master to port |
| sd_i | input | 1 | Data line as seen at the pad |
| share_i | input | 1 | High when two ports share the data line |
| slot_b_i | input | 1 | Channel strap for shared mode (low = voice A and control, high = voice B and signaling) |
| tx_voice_i | input | 8 | Voice byte to send |
| tx_ctrl_i | input | 8 | Control byte to send |
| tx_sig_i | input | 8 | Signaling byte to send |
| sd_o | output | 1 | Data value to drive onto the line |
| sd_oe_o | output | 1 | Pad output enable, high only in owned transmit slots |
| rx_valid_o | output | 1 | One-cycle strobe when a full receive half has arrived |
| rx_voice_a_o | output | 8 | Received voice A byte |
| rx_voice_b_o | output | 8 | Received voice B byte |
| rx_ctrl_o | output | 8 | Received control byte |
| rx_sig_o | output | 8 | Received signaling byte |
| rx_voice_o | output | 8 | Received voice byte of the slot this port owns |
| frame_err_o | output | 1 | One-cycle framing error pulse |

## Verification
The assertions assume a well-behaved master. Each level of the bit clock must last several system clocks, longer than the synchronizer depth plus one. The direction signal must change only together with a bit-clock rising edge. The data line must be stable at each falling edge. Under these conditions, a direction edge never falls in the same synchronized cycle as the 32nd received falling edge. The bench meets these conditions by running the bit clock at 16 system clocks per bit and changing clock, direction and data together on one system-clock falling edge. It changes straps and transmit bytes only between frames, and it breaks frame lengths only in the directed error cases.

// File: rtl/slp_pkg.sv
package slp_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_SLOTS = 4;
    localparam int HALF_BITS = BYTE_W * NUM_SLOTS;
    localparam int CNT_W     = $clog2(HALF_BITS) + 2;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int BIT_W     = $clog2(BYTE_W);

    // slot positions within a half frame; the order is the wire order
    localparam int SLOT_VA  = 0;
    localparam int SLOT_VB  = 1;
    localparam int SLOT_CTL = 2;
    localparam int SLOT_SIG = 3;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t HALF_CNT = cnt_t'(HALF_BITS);
    localparam cnt_t LAST_CNT = cnt_t'(HALF_BITS - 1);
    localparam cnt_t CNT_MAX  = '1;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RX   = 2'd1,
        PH_TX   = 2'd2
    } phase_e;

    typedef struct packed {
        logic [BYTE_W-1:0] voice_a;
        logic [BYTE_W-1:0] voice_b;
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] sig;
    } rx_frame_t;

    // Which transmit slots this port drives; bit k stands for slot k.
    function automatic logic [NUM_SLOTS-1:0] slot_owner(input logic shared,
                                                        input logic chan_b);
        logic [NUM_SLOTS-1:0] m;
        m = '0;
        if (!shared) begin
            m = '1;
        end else if (chan_b) begin
            m[SLOT_VB]  = 1'b1;
            m[SLOT_SIG] = 1'b1;
        end else begin
            m[SLOT_VA]  = 1'b1;
            m[SLOT_CTL] = 1'b1;
        end
        return m;
    endfunction

    // Transmit word in wire order; the voice byte fills both voice slots.
    function automatic logic [HALF_BITS-1:0] tx_word(input logic [BYTE_W-1:0] voice,
                                                     input logic [BYTE_W-1:0] ctrl,
                                                     input logic [BYTE_W-1:0] sig);
        return {voice, voice, ctrl, sig};
    endfunction

    function automatic rx_frame_t unpack_rx(input logic [HALF_BITS-1:0] w);
        rx_frame_t f;
        f.voice_a = w[HALF_BITS-1-SLOT_VA*BYTE_W -: BYTE_W];
        f.voice_b = w[HALF_BITS-1-SLOT_VB*BYTE_W -: BYTE_W];
        f.ctrl    = w[HALF_BITS-1-SLOT_CTL*BYTE_W -: BYTE_W];
        f.sig     = w[HALF_BITS-1-SLOT_SIG*BYTE_W -: BYTE_W];
        return f;
    endfunction

endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/slp_framer.sv
module slp_framer
    import slp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   bclk_s,
    input  logic   dir_s,
    input  cnt_t   rx_cnt,
    input  cnt_t   tx_cnt,
    output logic   bit_rise,
    output logic   bit_fall,
    output logic   dir_rise,
    output logic   dir_fall,
    output phase_e phase,
    output logic   load_tx,
    output logic   frame_err
);

    logic bclk_d;
    logic dir_d;
    logic rx_full;
    logic tx_full;

    assign bit_rise = bclk_s & ~bclk_d;
    assign bit_fall = ~bclk_s & bclk_d;
    assign dir_rise = dir_s & ~dir_d;
    assign dir_fall = ~dir_s & dir_d;

    assign rx_full = (rx_cnt == HALF_CNT);
    assign tx_full = (tx_cnt == HALF_CNT);

    assign load_tx = dir_fall && (phase == PH_RX) && rx_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_d    <= 1'b0;
            dir_d     <= 1'b0;
            phase     <= PH_IDLE;
            frame_err <= 1'b0;
        end else begin
            bclk_d    <= bclk_s;
            dir_d     <= dir_s;
            frame_err <= 1'b0;
            if (dir_rise) begin
                if (phase == PH_TX && !tx_full) begin
                    frame_err <= 1'b1;
                end
                phase <= PH_RX;
            end else if (dir_fall) begin
                if (phase == PH_RX && rx_full) begin
                    phase <= PH_TX;
                end else begin
                    if (phase == PH_RX) begin
                        frame_err <= 1'b1;
                    end
                    phase <= PH_IDLE;
                end
            end
        end
    end

endmodule

// File: rtl/slp_rx.sv
module slp_rx
    import slp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              sample,
    input  logic              active,
    input  logic              din,
    input  logic              shared,
    input  logic              chan_b,
    output cnt_t              cnt,
    output rx_frame_t         frame,
    output logic [BYTE_W-1:0] voice,
    output logic              valid
);

    logic [HALF_BITS-2:0] shreg;
    logic [HALF_BITS-1:0] next_word;
    rx_frame_t            next_frame;

    assign next_word  = {shreg, din};
    assign next_frame = unpack_rx(next_word);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            cnt   <= '0;
            frame <= '0;
            voice <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (start) begin
                cnt <= '0;
            end else if (sample && active) begin
                shreg <= next_word[HALF_BITS-2:0];
                if (cnt != CNT_MAX) begin
                    cnt <= cnt + 1'b1;
                end
                if (cnt == LAST_CNT) begin
                    frame <= next_frame;
                    voice <= (shared && chan_b) ? next_frame.voice_b : next_frame.voice_a;
                    valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/slp_tx.sv
module slp_tx
    import slp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 step,
    input  logic                 active,
    input  logic                 stop,
    input  logic [HALF_BITS-1:0] word,
    input  logic [NUM_SLOTS-1:0] own_in,
    output logic                 sd,
    output logic                 oe,
    output cnt_t                 cnt
);

    logic [HALF_BITS-2:0] shreg;
    logic [NUM_SLOTS-1:0] own;
    logic [SLOT_W-1:0]    slot;

    assign slot = cnt[BIT_W +: SLOT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            own   <= '0;
            cnt   <= '0;
            sd    <= 1'b0;
            oe    <= 1'b0;
        end else if (stop) begin
            cnt <= '0;
            sd  <= 1'b0;
            oe  <= 1'b0;
        end else if (load) begin
            sd    <= word[HALF_BITS-1];
            shreg <= word[HALF_BITS-2:0];
            own   <= own_in;
            oe    <= own_in[SLOT_VA];
            cnt   <= cnt_t'(1);
        end else if (step && active) begin
            if (cnt < HALF_CNT) begin
                sd    <= shreg[HALF_BITS-2];
                shreg <= {shreg[HALF_BITS-3:0], 1'b0};
                oe    <= own[slot];
            end else begin
                sd <= 1'b0;
                oe <= 1'b0;
            end
            if (cnt != CNT_MAX) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/slp_port.sv
module slp_port
    import slp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bclk_i,
    input  logic              dir_i,
    input  logic              sd_i,
    input  logic              share_i,
    input  logic              slot_b_i,
    input  logic [BYTE_W-1:0] tx_voice_i,
    input  logic [BYTE_W-1:0] tx_ctrl_i,
    input  logic [BYTE_W-1:0] tx_sig_i,
    output logic              sd_o,
    output logic              sd_oe_o,
    output logic              rx_valid_o,
    output logic [BYTE_W-1:0] rx_voice_a_o,
    output logic [BYTE_W-1:0] rx_voice_b_o,
    output logic [BYTE_W-1:0] rx_ctrl_o,
    output logic [BYTE_W-1:0] rx_sig_o,
    output logic [BYTE_W-1:0] rx_voice_o,
    output logic              frame_err_o
);

    localparam int LINK_W = 3;

    logic [LINK_W-1:0] link_s;
    logic              bclk_s;
    logic              dir_s;
    logic              sd_s;

    logic   bit_rise;
    logic   bit_fall;
    logic   dir_rise;
    logic   dir_fall;
    logic   load_tx;
    phase_e phase;
    logic   rx_phase;
    logic   tx_phase;
    cnt_t   rx_cnt;
    cnt_t   tx_cnt;

    rx_frame_t            rx_frame;
    logic [HALF_BITS-1:0] tx_bits;
    logic [NUM_SLOTS-1:0] own_mask;

    slp_sync #(
        .W      (LINK_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sd_i, dir_i, bclk_i}),
        .q   (link_s)
    );

    assign bclk_s = link_s[0];
    assign dir_s  = link_s[1];
    assign sd_s   = link_s[2];

    slp_framer u_framer (
        .clk       (clk),
        .rst       (rst),
        .bclk_s    (bclk_s),
        .dir_s     (dir_s),
        .rx_cnt    (rx_cnt),
        .tx_cnt    (tx_cnt),
        .bit_rise  (bit_rise),
        .bit_fall  (bit_fall),
        .dir_rise  (dir_rise),
        .dir_fall  (dir_fall),
        .phase     (phase),
        .load_tx   (load_tx),
        .frame_err (frame_err_o)
    );

    assign rx_phase = (phase == PH_RX);
    assign tx_phase = (phase == PH_TX);

    slp_rx u_rx (
        .clk    (clk),
        .rst    (rst),
        .start  (dir_rise),
        .sample (bit_fall),
        .active (rx_phase),
        .din    (sd_s),
        .shared (share_i),
        .chan_b (slot_b_i),
        .cnt    (rx_cnt),
        .frame  (rx_frame),
        .voice  (rx_voice_o),
        .valid  (rx_valid_o)
    );

    assign rx_voice_a_o = rx_frame.voice_a;
    assign rx_voice_b_o = rx_frame.voice_b;
    assign rx_ctrl_o    = rx_frame.ctrl;
    assign rx_sig_o     = rx_frame.sig;

    assign tx_bits  = tx_word(tx_voice_i, tx_ctrl_i, tx_sig_i);
    assign own_mask = slot_owner(share_i, slot_b_i);

    slp_tx u_tx (
        .clk    (clk),
        .rst    (rst),
        .load   (load_tx),
        .step   (bit_rise),
        .active (tx_phase),
        .stop   (dir_rise),
        .word   (tx_bits),
        .own_in (own_mask),
        .sd     (sd_o),
        .oe     (sd_oe_o),
        .cnt    (tx_cnt)
    );

endmodule

// File: rtl/slp_port_chk.sv
module slp_port_chk
    import slp_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 sd_oe_o,
    input logic                 rx_valid_o,
    input logic                 frame_err_o,
    input logic [5*BYTE_W-1:0]  rx_bus,
    input logic                 tx_phase,
    input logic                 dir_rise,
    input logic                 dir_fall
);

    AST_OE_IN_TX_HALF: assert property (@(posedge clk) disable iff (rst)
        sd_oe_o |-> tx_phase); // R7

    AST_OE_DROP_ON_START: assert property (@(posedge clk) disable iff (rst)
        dir_rise |=> !sd_oe_o); // R7

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o); // R2

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rx_valid_o |-> $stable(rx_bus)); // R2

    AST_ERR_AT_DIR_EDGE: assert property (@(posedge clk) disable iff (rst)
        frame_err_o |-> $past(dir_rise || dir_fall)); // R8

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sd_oe_o && !rx_valid_o && !frame_err_o)); // R11

endmodule

bind slp_port slp_port_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .sd_oe_o     (sd_oe_o),
    .rx_valid_o  (rx_valid_o),
    .frame_err_o (frame_err_o),
    .rx_bus      ({rx_voice_a_o, rx_voice_b_o, rx_ctrl_o, rx_sig_o, rx_voice_o}),
    .tx_phase    (tx_phase),
    .dir_rise    (dir_rise),
    .dir_fall    (dir_fall)
);

// File: tb/tb_slp_port.sv
module tb_slp_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bclk = 1'b0;
    logic       dir = 1'b0;
    logic       sd = 1'b0;
    logic       share = 1'b0;
    logic       slb = 1'b0;
    logic [7:0] tv = '0;
    logic [7:0] tc = '0;
    logic [7:0] ts = '0;

    logic       sd_o;
    logic       sd_oe_o;
    logic       rx_valid_o;
    logic [7:0] rx_voice_a_o;
    logic [7:0] rx_voice_b_o;
    logic [7:0] rx_ctrl_o;
    logic [7:0] rx_sig_o;
    logic [7:0] rx_voice_o;
    logic       frame_err_o;

    int checks = 0;
    int errors = 0;
    int val_cnt = 0;
    int err_cnt = 0;
    int pend = 0;
    bit done = 1'b0;
    logic [7:0] cap_a = '0;
    logic [7:0] cap_b = '0;
    logic [7:0] cap_c = '0;
    logic [7:0] cap_s = '0;
    logic [7:0] cap_v = '0;

    always #2 clk = ~clk;

    slp_port dut (
        .clk          (clk),
        .rst          (rst),
        .bclk_i       (bclk),
        .dir_i        (dir),
        .sd_i         (sd),
        .share_i      (share),
        .slot_b_i     (slb),
        .tx_voice_i   (tv),
        .tx_ctrl_i    (tc),
        .tx_sig_i     (ts),
        .sd_o         (sd_o),
        .sd_oe_o      (sd_oe_o),
        .rx_valid_o   (rx_valid_o),
        .rx_voice_a_o (rx_voice_a_o),
        .rx_voice_b_o (rx_voice_b_o),
        .rx_ctrl_o    (rx_ctrl_o),
        .rx_sig_o     (rx_sig_o),
        .rx_voice_o   (rx_voice_o),
        .frame_err_o  (frame_err_o)
    );

    always @(negedge clk) begin
        if (rx_valid_o) begin
            val_cnt = val_cnt + 1;
            cap_a = rx_voice_a_o;
            cap_b = rx_voice_b_o;
            cap_c = rx_ctrl_o;
            cap_s = rx_sig_o;
            cap_v = rx_voice_o;
        end
        if (frame_err_o) err_cnt = err_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit owns(input bit sh, input bit b, input int k);
        if (!sh) return 1'b1;
        if (b) return (k == 1) || (k == 3);
        return (k == 0) || (k == 2);
    endfunction

    // one bit slot: 8 system clocks high, 8 low; check mid high phase
    task automatic bit_slot(input logic dv, input logic d, input bit exp_oe,
                            input logic exp_d, input string req_oe);
        @(negedge clk);
        bclk = 1'b1;
        dir  = dv;
        sd   = d;
        repeat (7) @(negedge clk);
        chk(sd_oe_o == exp_oe, req_oe, "output enable", sd_oe_o, exp_oe);
        if (exp_oe) chk(sd_o == exp_d, "R4", "tx data bit", sd_o, exp_d);
        @(negedge clk);
        bclk = 1'b0;
        repeat (7) @(negedge clk);
    endtask

    task automatic run_frame(input logic [31:0] rxw, input int nrx, input int ntx,
                             input bit sh, input bit b,
                             input logic [7:0] v, input logic [7:0] c, input logic [7:0] s);
        logic [31:0] txw;
        bit sends;
        bit eoe;
        string r;
        @(negedge clk);
        share = sh;
        slb   = b;
        tv    = v;
        tc    = c;
        ts    = s;
        val_cnt = 0;
        err_cnt = 0;
        for (int i = 0; i < nrx; i++) begin
            bit_slot(1'b1, (i < 32) ? rxw[31-i] : 1'b0, 1'b0, 1'b0, "R7");
        end
        chk(val_cnt == ((nrx >= 32) ? 1 : 0), "R2", "strobe count", val_cnt, (nrx >= 32) ? 1 : 0);
        if (nrx >= 32) begin
            chk(cap_a == rxw[31:24], "R1", "voice A", cap_a, rxw[31:24]);
            chk(cap_b == rxw[23:16], "R1", "voice B", cap_b, rxw[23:16]);
            chk(cap_c == rxw[15:8],  "R1", "control", cap_c, rxw[15:8]);
            chk(cap_s == rxw[7:0],   "R1", "signaling", cap_s, rxw[7:0]);
            chk(cap_v == ((sh && b) ? rxw[23:16] : rxw[31:24]), "R3", "owned voice",
                cap_v, (sh && b) ? rxw[23:16] : rxw[31:24]);
        end
        if (pend != 0) chk(err_cnt == 1, "R9", "error at frame start", err_cnt, 1);
        else           chk(err_cnt == 0, "R10", "error at frame start", err_cnt, 0);
        sends   = (nrx == 32);
        txw     = {v, v, c, s};
        val_cnt = 0;
        err_cnt = 0;
        for (int j = 0; j < ntx; j++) begin
            eoe = sends && (j < 32) && owns(sh, b, j / 8);
            if (!sends || j >= 32) r = "R7";
            else if (sh)           r = "R6";
            else                   r = "R5";
            bit_slot(1'b0, 1'b0, eoe, (j < 32) ? txw[31-j] : 1'b0, r);
        end
        chk(err_cnt == (sends ? 0 : 1), "R8", "error at direction fall", err_cnt, sends ? 0 : 1);
        chk(val_cnt == 0, "R2", "strobe during transmit half", val_cnt, 0);
        pend = (sends && ntx != 32) ? 1 : 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (6) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk(sd_oe_o == 1'b0, "R11", "oe after reset", sd_oe_o, 0);
        chk(rx_valid_o == 1'b0, "R11", "strobe after reset", rx_valid_o, 0);
        chk(frame_err_o == 1'b0, "R11", "error after reset", frame_err_o, 0);
        chk({rx_voice_a_o, rx_voice_b_o, rx_ctrl_o, rx_sig_o, rx_voice_o} == 40'd0,
            "R11", "rx bytes after reset",
            {rx_voice_a_o, rx_voice_b_o, rx_ctrl_o, rx_sig_o, rx_voice_o}, 0);

        // directed: single device, then both shared straps
        run_frame(32'hA5C3_3C5A, 32, 32, 1'b0, 1'b0, 8'h81, 8'h42, 8'h7E);
        run_frame(32'h0123_4567, 32, 32, 1'b1, 1'b0, 8'hF0, 8'h0F, 8'h99);
        run_frame(32'hFEDC_BA98, 32, 32, 1'b1, 1'b1, 8'h3C, 8'hC3, 8'h5A);
        // R8: short receive half, then a clean frame from idle (R10)
        run_frame(32'hFFFF_0000, 20, 32, 1'b0, 1'b0, 8'hAA, 8'h55, 8'hFF);
        run_frame(32'h8000_0001, 32, 32, 1'b0, 1'b0, 8'h01, 8'h80, 8'h7F);
        // R9: long transmit half, then short transmit half
        run_frame(32'h1357_9BDF, 32, 36, 1'b0, 1'b0, 8'hE7, 8'h18, 8'h66);
        run_frame(32'h2468_ACE0, 32, 30, 1'b1, 1'b1, 8'h11, 8'h22, 8'h33);
        run_frame(32'hDEAD_BEEF, 32, 32, 1'b1, 1'b0, 8'h44, 8'h55, 8'h66);
        // R8: long receive half
        run_frame(32'hCAFE_F00D, 34, 32, 1'b0, 1'b0, 8'h77, 8'h88, 8'h99);
        run_frame(32'h0000_0000, 32, 32, 1'b0, 1'b0, 8'hFF, 8'hFF, 8'hFF);
        run_frame(32'hFFFF_FFFF, 32, 32, 1'b1, 1'b1, 8'h00, 8'h00, 8'h00);

        for (int k = 0; k < 40; k++) begin
            logic [31:0] w;
            logic [31:0] t;
            w = $urandom();
            t = $urandom();
            run_frame(w, 32, 32, t[24], t[25], t[7:0], t[15:8], t[23:16]);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule